// File: doc/BRIEF.md
# Attribute-Steered Store Buffer

This block sits between a processor's store port and a memory bus. Each write arrives with a 3-bit attribute code and is held in a small queue. The code says one of three things about the write: whether it may be combined with a later write to the same word, whether it may overtake older buffered writes, and whether its completion can go back upstream as soon as the buffer takes it. The alternative is to hold the completion until the target's response for that write has arrived. Normal memory accepts all three relaxations. Four device classes, from strictest to loosest, accept progressively more of them.

The write channels are valid/ready on both sides. Downstream writes carry a small entry identifier, and the bus echoes it with its response pulse. Upstream completions carry the tag the processor supplied with the write, and they come back in acceptance order, each held until taken. An entry is released once it has been sent downstream, answered by the bus and completed upstream.

Top module: `dev_wbuf`

## Requirements
- R1: After reset the buffer is empty: `s_ready` is 1, while `m_valid` and `s_bvalid` are 0.
- R2: Codes 1, 2 and 3 never combine. Each accepted write with one of these codes leaves downstream as exactly one write, with its own address, data and byte strobes.
- R3: Codes 0 (Normal) and 4 (loosest device class) combine under four conditions: the incoming write has the same code and the same word address (`addr[31:2]`) as the youngest buffered entry; that entry has not been sent downstream; the entry is not being sent in the same cycle; and the entry's completion has been returned or is returned in that cycle. The incoming strobed byte lanes replace the entry's lanes, the strobes are ORed, the entry takes the new tag, and a single downstream write results.
- R4: Selection among unsent entries works as follows. Eligible device entries (codes 1 to 7) go before eligible Normal entries, and the oldest goes first within each group. An entry is ineligible in two cases: while an older unsent entry has the same word address, or while an older unsent entry lies in the same 4 KiB block (`addr[31:12]`) and either of the two has code 1, 2 or 5 to 7.
- R5: A write with code 1 gets its upstream completion only after a downstream response whose `m_bid` equals the identifier it was sent with.
- R6: Writes with codes 0, 2, 3 and 4 offer their upstream completion in the cycle after acceptance, with no downstream response needed.
- R7: Upstream completions return in acceptance order, each carrying its write's tag, and are held stable while `s_bready` is 0. A late completion that is still pending holds back all younger completions.
- R8: `s_ready` is 0 while 4 entries are held. An entry is freed in the cycle after the last of three events: it was sent, its response arrived, and its completion was taken.
- R9: While `m_valid` is 1 and `m_ready` is 0, the offered write keeps its identifier and address, even if a higher-priority write arrives in the meantime.
- R10: Codes 5 to 7 behave exactly like code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Upstream write valid |
| s_ready | output | 1 | Upstream write accepted |
| s_addr | input | 32 | Byte address of the write |
| s_data | input | 32 | Write data, byte lane i in bits 8i+7:8i |
| s_strb | input | 4 | Byte lane enables |
| s_attr | input | 3 | Attribute code (0 Normal, 1 to 4 device classes from strictest to loosest) |
| s_tag | input | 4 | Upstream tag returned with the completion |
| s_bvalid | output | 1 | Upstream completion valid |
| s_bready | input | 1 | Upstream completion taken |
| s_btag | output | 4 | Tag of the completed write |
| m_valid | output | 1 | Downstream write valid |
| m_ready | input | 1 | Downstream write accepted |
| m_addr | output | 32 | Downstream address |
| m_data | output | 32 | Downstream data |
| m_strb | output | 4 | Downstream byte strobes |
| m_id | output | 2 | Entry identifier of the downstream write |
| m_bvalid | input | 1 | Downstream response pulse |
| m_bid | input | 2 | Identifier of the responded write |

## Verification
The hardest case to reach is a selection decision with several writes waiting at once. Any write that arrives alone is offered downstream at once and then held by the stall rule, so priority and block ordering never show up with simple back-to-back pushes. The stimulus therefore first puts a strict-class write in a distinct block at the head and keeps the bus stalled. It then queues the pair under test behind that head and releases the bus one write at a time. Combining also needs precise timing, because the youngest entry's completion must be taken in the same cycle the second byte write arrives.

// File: rtl/dev_wbuf.sv
module dev_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int TW    = 4,
  parameter int BLK   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_addr,
  input  logic [31:0]   s_data,
  input  logic [3:0]    s_strb,
  input  logic [2:0]    s_attr,
  input  logic [TW-1:0] s_tag,
  output logic          s_bvalid,
  input  logic          s_bready,
  output logic [TW-1:0] s_btag,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_data,
  output logic [3:0]    m_strb,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] m_id,
  input  logic          m_bvalid,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] m_bid
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic          iss;
    logic          ack;
    logic          done;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [3:0]    strb;
    logic [2:0]    attr;
    logic [TW-1:0] tag;
    logic [IW-1:0] id;
  } ent_t;

  function automatic logic can_merge(input logic [2:0] a);
    return a == 3'd0 || a == 3'd4;
  endfunction
  function automatic logic can_pass(input logic [2:0] a);
    return a == 3'd0 || a == 3'd3 || a == 3'd4;
  endfunction
  function automatic logic early_ok(input logic [2:0] a);
    return a == 3'd0 || a == 3'd2 || a == 3'd3 || a == 3'd4;
  endfunction

  ent_t             q  [DEPTH];
  ent_t             t  [DEPTH];
  ent_t             nq [DEPTH];
  logic [DEPTH-1:0] q_vld, nv, elig, used;
  logic             lock;
  logic [IW-1:0]    lock_id;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    sel, hd, y, nid;
  logic             sel_ok, hd_ok, mrg;
  logic             s_fire, m_fire, b_fire;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(q_vld[i]);
  end

  always_comb begin
    logic          dok, nok;
    logic [IW-1:0] dsel, nsel, lsel;
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = q_vld[i] && !q[i].iss;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && q_vld[j] && !q[j].iss &&
            (q[j].addr[AW-1:2] == q[i].addr[AW-1:2] ||
             (q[j].addr[AW-1:BLK] == q[i].addr[AW-1:BLK] &&
              !(can_pass(q[j].attr) && can_pass(q[i].attr)))))
          elig[i] = 1'b0;
    end
    dok = 1'b0; nok = 1'b0; dsel = '0; nsel = '0; lsel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i] && q[i].attr != 3'd0) begin dsel = IW'(i); dok = 1'b1; end
      if (elig[i] && q[i].attr == 3'd0) begin nsel = IW'(i); nok = 1'b1; end
      if (q_vld[i] && !q[i].iss && q[i].id == lock_id) lsel = IW'(i);
    end
    sel_ok = lock || dok || nok;
    sel    = lock ? lsel : (dok ? dsel : nsel);
  end

  always_comb begin
    hd_ok = 1'b0; hd = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (q_vld[i] && !q[i].ack) begin hd = IW'(i); hd_ok = 1'b1; end
    used = '0;
    for (int i = 0; i < DEPTH; i++) if (q_vld[i]) used[q[i].id] = 1'b1;
    nid = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!used[i]) nid = IW'(i);
  end

  assign s_ready  = cnt < CW'(DEPTH);
  assign m_valid  = sel_ok;
  assign m_addr   = q[sel].addr;
  assign m_data   = q[sel].data;
  assign m_strb   = q[sel].strb;
  assign m_id     = q[sel].id;
  assign s_bvalid = hd_ok && (early_ok(q[hd].attr) || q[hd].done);
  assign s_btag   = q[hd].tag;
  assign s_fire   = s_valid && s_ready;
  assign m_fire   = m_valid && m_ready;
  assign b_fire   = s_bvalid && s_bready;
  assign y        = IW'(cnt - CW'(1));

  assign mrg = s_fire && cnt != '0 && !q[y].iss && !(m_fire && sel == y) &&
               (q[y].ack || (b_fire && hd == y)) &&
               q[y].addr[AW-1:2] == s_addr[AW-1:2] &&
               q[y].attr == s_attr && can_merge(s_attr);

  always_comb begin
    int k;
    t = q;
    for (int i = 0; i < DEPTH; i++)
      if (m_bvalid && q_vld[i] && q[i].iss && q[i].id == m_bid) t[i].done = 1'b1;
    if (m_fire) t[sel].iss = 1'b1;
    if (b_fire) t[hd].ack = 1'b1;
    if (mrg) begin
      for (int b = 0; b < 4; b++)
        if (s_strb[b]) t[y].data[8*b +: 8] = s_data[8*b +: 8];
      t[y].strb = t[y].strb | s_strb;
      t[y].tag  = s_tag;
      t[y].ack  = 1'b0;
    end
    nq = t;
    nv = '0;
    k  = 0;
    for (int i = 0; i < DEPTH; i++)
      if (q_vld[i] && !(t[i].iss && t[i].done && t[i].ack)) begin
        nq[k] = t[i];
        nv[k] = 1'b1;
        k = k + 1;
      end
    if (s_fire && !mrg && k < DEPTH) begin
      nq[k].iss  = 1'b0;
      nq[k].ack  = 1'b0;
      nq[k].done = 1'b0;
      nq[k].addr = s_addr;
      nq[k].data = s_data;
      nq[k].strb = s_strb;
      nq[k].attr = s_attr;
      nq[k].tag  = s_tag;
      nq[k].id   = nid;
      nv[k]      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld   <= '0;
      lock    <= 1'b0;
      lock_id <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      q_vld <= nv;
      q     <= nq;
      if (m_fire) lock <= 1'b0;
      else if (m_valid) begin
        lock    <= 1'b1;
        lock_id <= m_id;
      end
    end
  end

  logic resp_hit;
  always_comb begin
    resp_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (q_vld[i] && q[i].iss && !q[i].done && q[i].id == m_bid) resp_hit = 1'b1;
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_id) && $stable(m_addr));

  assert_bresp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_btag));

  assert_push_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && !m_bvalid && !b_fire && !mrg |=> cnt == $past(cnt) + CW'(1));

  assert_sel_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> q_vld[sel] && !q[sel].iss);

  assert_resp_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid |-> resp_hit);
endmodule

// File: tb/tb_dev_wbuf.sv
module tb_dev_wbuf;
  logic        clk = 0, rst_n = 0;
  logic        s_valid = 0, s_bready = 0, m_ready = 0, m_bvalid = 0;
  logic [31:0] s_addr = 0, s_data = 0;
  logic [3:0]  s_strb = 0, s_tag = 0;
  logic [2:0]  s_attr = 0;
  logic [1:0]  m_bid = 0;
  logic        s_ready, s_bvalid, m_valid;
  logic [3:0]  s_btag, m_strb;
  logic [31:0] m_addr, m_data;
  logic [1:0]  m_id;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dev_wbuf dut (.clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_addr(s_addr), .s_data(s_data), .s_strb(s_strb), .s_attr(s_attr), .s_tag(s_tag),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_btag(s_btag), .m_valid(m_valid),
    .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_strb(m_strb), .m_id(m_id),
    .m_bvalid(m_bvalid), .m_bid(m_bid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] sb,
                      input logic [2:0] at, input logic [3:0] tg);
    int n = 0;
    s_valid = 1; s_addr = a; s_data = d; s_strb = sb; s_attr = at; s_tag = tg;
    while (!s_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic ds_take(output logic [1:0] id, output logic [31:0] a,
                         output logic [31:0] d, output logic [3:0] sb);
    int n = 0;
    while (!m_valid && n < 50) begin @(negedge clk); n++; end
    id = m_id; a = m_addr; d = m_data; sb = m_strb;
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic ds_resp(input logic [1:0] id);
    m_bvalid = 1; m_bid = id;
    @(negedge clk);
    m_bvalid = 0;
  endtask

  task automatic up_take(input string req, input logic [3:0] exp);
    int n = 0;
    while (!s_bvalid && n < 50) begin @(negedge clk); n++; end
    chk(req, {s_bvalid, 27'd0, s_btag}, {1'b1, 27'd0, exp});
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic t_reset;
    chk("R1 s_ready", s_ready, 1);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 s_bvalid", s_bvalid, 0);
  endtask

  task automatic t_late_ack;
    logic [1:0] id; logic [31:0] a, d; logic [3:0] sb;
    push(32'h1000, 32'hCAFE0001, 4'hF, 3'd1, 4'd3);
    chk("R5 no early completion", s_bvalid, 0);
    ds_take(id, a, d, sb);
    chk("R2 addr", a, 32'h1000);
    chk("R2 data", d, 32'hCAFE0001);
    chk("R2 strb", sb, 4'hF);
    repeat (3) @(negedge clk);
    chk("R5 waits for response", s_bvalid, 0);
    ds_resp(id);
    up_take("R5 completion after response", 4'd3);
  endtask

  task automatic t_merge;
    logic [1:0] id; logic [31:0] a, d; logic [3:0] sb;
    push(32'h2000, 32'h00000011, 4'b0001, 3'd4, 4'd1);
    chk("R6 early completion", {s_bvalid, s_btag}, {1'b1, 4'd1});
    s_bready = 1; s_valid = 1; s_addr = 32'h2001; s_data = 32'h00002200;
    s_strb = 4'b0010; s_attr = 3'd4; s_tag = 4'd2;
    @(negedge clk);
    s_valid = 0; s_bready = 0;
    up_take("R3 merged tag", 4'd2);
    ds_take(id, a, d, sb);
    chk("R3 addr", a, 32'h2000);
    chk("R3 strb", sb, 4'b0011);
    chk("R3 data", d, 32'h00002211);
    chk("R3 single write", m_valid, 0);
    ds_resp(id);
  endtask

  task automatic t_no_merge;
    logic [1:0] i0, i1; logic [31:0] a, d; logic [3:0] s0, s1;
    push(32'h3000, 32'h00000033, 4'b0001, 3'd3, 4'd4);
    up_take("R6 early code3", 4'd4);
    push(32'h3001, 32'h00004400, 4'b0010, 3'd3, 4'd5);
    up_take("R6 early code3 second", 4'd5);
    ds_take(i0, a, d, s0);
    chk("R2 first strb", s0, 4'b0001);
    ds_take(i1, a, d, s1);
    chk("R2 second strb", s1, 4'b0010);
    ds_resp(i0); ds_resp(i1);
  endtask

  task automatic t_order(input string req, input logic [31:0] an, input logic [2:0] atd,
                         input logic [31:0] ad, input logic [31:0] first, input logic [31:0] second);
    logic [1:0] ip, i1, i2; logic [31:0] a1, a2, d; logic [3:0] sb;
    push(32'hF000, 32'h1, 4'hF, 3'd1, 4'd6);
    push(an, 32'h2, 4'hF, 3'd0, 4'd7);
    push(ad, 32'h3, 4'hF, atd, 4'd8);
    ds_take(ip, a1, d, sb);
    chk({req, " plug"}, a1, 32'hF000);
    ds_take(i1, a1, d, sb);
    chk({req, " first"}, a1, first);
    ds_take(i2, a2, d, sb);
    chk({req, " second"}, a2, second);
    ds_resp(ip); ds_resp(i1); ds_resp(i2);
    up_take("R7 order a", 4'd6);
    up_take("R7 order b", 4'd7);
    up_take("R7 order c", 4'd8);
  endtask

  task automatic t_ack_order;
    logic [1:0] is, ie; logic [31:0] a, d; logic [3:0] sb;
    push(32'h8000, 32'h8, 4'hF, 3'd1, 4'd8);
    push(32'h9000, 32'h9, 4'hF, 3'd3, 4'd9);
    chk("R7 strict head blocks", s_bvalid, 0);
    ds_take(is, a, d, sb);
    chk("R4 oldest device first", a, 32'h8000);
    ds_take(ie, a, d, sb);
    ds_resp(ie);
    chk("R7 younger held back", s_bvalid, 0);
    ds_resp(is);
    up_take("R7 first tag", 4'd8);
    up_take("R7 second tag", 4'd9);
  endtask

  task automatic t_full;
    logic [1:0] id; logic [31:0] a, d; logic [3:0] sb;
    for (int i = 0; i < 4; i++) push(32'hA000 + 32'(i * 16), 32'(i), 4'hF, 3'd0, 4'(11 + i));
    chk("R8 full stalls", s_ready, 0);
    ds_take(id, a, d, sb);
    chk("R8 oldest out", a, 32'hA000);
    ds_resp(id);
    chk("R8 not freed before completion", s_ready, 0);
    up_take("R8 tag", 4'd11);
    chk("R8 freed", s_ready, 1);
    for (int i = 1; i < 4; i++) begin
      ds_take(id, a, d, sb);
      chk("R8 drain order", a, 32'hA000 + 32'(i * 16));
      ds_resp(id);
      up_take("R8 drain tag", 4'(11 + i));
    end
  endtask

  task automatic t_stall;
    logic [1:0] i1, i2; logic [31:0] a, d; logic [3:0] sb;
    push(32'hB000, 32'h1, 4'hF, 3'd0, 4'd1);
    push(32'hC000, 32'h2, 4'hF, 3'd2, 4'd2);
    chk("R9 held addr", m_addr, 32'hB000);
    repeat (2) @(negedge clk);
    chk("R9 still held", m_addr, 32'hB000);
    ds_take(i1, a, d, sb);
    ds_take(i2, a, d, sb);
    chk("R9 then device", a, 32'hC000);
    ds_resp(i1); ds_resp(i2);
    up_take("R7 tag stall a", 4'd1);
    up_take("R7 tag stall b", 4'd2);
  endtask

  task automatic t_code6;
    logic [1:0] i0, i1; logic [31:0] a, d; logic [3:0] s0;
    push(32'hD000, 32'h000000AA, 4'b0001, 3'd6, 4'd10);
    push(32'hD001, 32'h0000BB00, 4'b0010, 3'd6, 4'd11);
    chk("R10 late like code1", s_bvalid, 0);
    ds_take(i0, a, d, s0);
    chk("R10 no combining", s0, 4'b0001);
    ds_take(i1, a, d, s0);
    repeat (2) @(negedge clk);
    chk("R10 waits response", s_bvalid, 0);
    ds_resp(i0);
    up_take("R10 completion", 4'd10);
    ds_resp(i1);
    up_take("R10 completion 2", 4'd11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_late_ack();
    t_merge();
    t_no_merge();
    t_order("R4 device over normal", 32'h4000, 3'd2, 32'h5000, 32'h5000, 32'h4000);
    t_order("R4 same block no pass", 32'h6000, 3'd2, 32'h6004, 32'h6000, 32'h6004);
    t_order("R4 same block pass", 32'h7000, 3'd4, 32'h7008, 32'h7008, 32'h7000);
    t_ack_order();
    t_full();
    t_stall();
    t_code6();
    repeat (2) @(negedge clk);
    chk("R1 idle at end", {s_bvalid, m_valid, s_ready}, 3'b001);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule